// File: doc/BRIEF.md
# Chained Vector Register Pipeline

This block is a small integer vector execution unit. It owns a file of vector registers. One instruction names a destination register, two source registers, an opcode, a scalar operand and a vector length. The unit then streams that many element pairs through a fixed-depth arithmetic pipeline and writes one result element per clock into the destination register. Startup is a handful of cycles, so short vectors still run close to full rate.

Two execution lanes share the register file. A second instruction may start while the first is still running. If the second instruction reads the first one's destination, it is chained: each of its element reads waits only until that particular element has been written, not until the whole vector is finished. A per-element written flag in a scoreboard decides when such a read may go ahead. A host port writes and reads single elements, so the register contents can be loaded and inspected.

Top module: `vpu_chain_unit`

## Requirements
- R1: During and right after reset, `busy` is low and every `done` bit is low.
- R2: Opcode 0 writes `a[i] + b[i]` modulo 2^64 into element i of the destination, for every i below `vlen`.
- R3: Opcode 1 writes the low 64 bits of `a[i] * b[i]` into element i of the destination, for every i below `vlen`.
- R4: Opcode 2 writes `a[i] * scalar + b[i]` modulo 2^64 into element i of the destination, for every i below `vlen`.
- R5: Destination elements at index `vlen` or above keep their previous contents.
- R6: An accepted instruction goes to the lowest-numbered free lane. That lane's `done` bit is a one-cycle pulse that appears exactly `DEPTH + vlen` clock edges after the accepting edge (DEPTH is 4 by default).
- R7: Chaining. A consumer is accepted one cycle after its producer, reads the producer's destination, and has the same length. It receives the producer's new results, and its `done` pulse comes exactly `DEPTH + 1` cycles after the producer's.
- R8: `busy` is high while every lane holds an instruction. A `start` in such a cycle is ignored and leaves all registers unchanged.
- R9: A `start` is refused in any of these cases: opcode 3, `vlen` of 0, `vlen` above 64, or a `vd` that is the destination or a source of a running instruction. A refused start produces no `done` pulse and writes nothing.
- R10: An instruction whose destination is also one of its sources reads the old value of each element, before that element is overwritten.
- R11: Two lanes never write the same register in the same cycle.
- R12: A host write stores one element (`hw_reg`, `hw_idx`) at the next edge. The host read port returns that element combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a vector instruction |
| op | input | 2 | 0 add, 1 multiply, 2 multiply by scalar then add, 3 reserved |
| vd | input | 3 | Destination register index |
| va | input | 3 | First source register index |
| vb | input | 3 | Second source register index |
| scalar | input | 64 | Scalar operand for opcode 2 |
| vlen | input | 7 | Number of elements to process, 1 to 64 |
| busy | output | 1 | All lanes occupied |
| done | output | 2 | Per-lane completion pulse |
| hw_en | input | 1 | Host element write enable |
| hw_reg | input | 3 | Host write register index |
| hw_idx | input | 6 | Host write element index |
| hw_data | input | 64 | Host write data |
| hr_reg | input | 3 | Host read register index |
| hr_idx | input | 6 | Host read element index |
| hr_data | output | 64 | Host read data |

## Verification
The hardest case to reach is a consumer that stalls on every single element, waiting for the matching producer write. The stimulus starts a dependent add in the cycle directly after a multiply that writes its source. The bench then checks the consumer's data and the exact spacing of the two `done` pulses. While both lanes are occupied, the bench issues a third start to confirm it is dropped. A separate test issues a write-after-write conflict and a write-after-read conflict against a running instruction.

// File: rtl/vpu_chain_pkg.sv
`timescale 1ns/1ps
package vpu_chain_pkg;
   typedef enum logic [1:0] {
      VOP_ADD = 2'd0,
      VOP_MUL = 2'd1,
      VOP_MAC = 2'd2,
      VOP_RSV = 2'd3
   } vop_e;
endpackage

// File: rtl/vpu_fu.sv
`timescale 1ns/1ps
// Element arithmetic pipeline. Stage 1 captures operands, stage 2 forms
// half-width partial products, stage 3 combines them, and later stages delay.
module vpu_fu
   import vpu_chain_pkg::*;
#(
   parameter int W     = 64,
   parameter int DEPTH = 4,
   parameter int TW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [1:0]    in_op,
   input  logic [W-1:0]  in_a,
   input  logic [W-1:0]  in_b,
   input  logic [W-1:0]  in_s,
   input  logic [TW-1:0] in_tag,
   output logic          out_vld,
   output logic [W-1:0]  out_data,
   output logic [TW-1:0] out_tag
);
   localparam int H = W / 2;

   initial begin : g_param_chk
      assert (DEPTH >= 3) else $error("vpu_fu: DEPTH must be at least 3");
      assert (W % 2 == 0) else $error("vpu_fu: W must be even");
   end

   // stage 1
   logic          v1, add1;
   logic [W-1:0]  a1, b1, m1, c1;
   logic [TW-1:0] t1;
   // stage 2
   logic          v2, add2;
   logic [W-1:0]  sum2, ll2, c2;
   logic [H-1:0]  cr2;
   logic [TW-1:0] t2;
   // stage 3 .. DEPTH
   logic [DEPTH:3] vq;
   logic [W-1:0]   dq [3:DEPTH];
   logic [TW-1:0]  tq [3:DEPTH];

   logic [H-1:0] cross_lh, cross_hl;
   assign cross_lh = a1[H-1:0] * m1[W-1:H];
   assign cross_hl = a1[W-1:H] * m1[H-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1 <= 1'b0;
         v2 <= 1'b0;
         vq <= '0;
      end else begin
         v1 <= in_vld;
         v2 <= v1;
         vq[3] <= v2;
         for (int k = 4; k <= DEPTH; k++) vq[k] <= vq[k-1];
      end
   end

   always_ff @(posedge clk) begin
      add1 <= (vop_e'(in_op) == VOP_ADD);
      a1   <= in_a;
      b1   <= in_b;
      m1   <= (vop_e'(in_op) == VOP_MAC) ? in_s : in_b;
      c1   <= (vop_e'(in_op) == VOP_MAC) ? in_b : '0;
      t1   <= in_tag;

      add2 <= add1;
      sum2 <= a1 + b1;
      ll2  <= W'(a1[H-1:0]) * W'(m1[H-1:0]);
      cr2  <= cross_lh + cross_hl;
      c2   <= c1;
      t2   <= t1;

      dq[3] <= add2 ? sum2 : (ll2 + {cr2, {H{1'b0}}} + c2);
      tq[3] <= t2;
      for (int k = 4; k <= DEPTH; k++) begin
         dq[k] <= dq[k-1];
         tq[k] <= tq[k-1];
      end
   end

   assign out_vld  = vq[DEPTH];
   assign out_data = dq[DEPTH];
   assign out_tag  = tq[DEPTH];
endmodule

// File: rtl/vpu_regfile.sv
`timescale 1ns/1ps
// Vector register storage: multi-ported, later write ports win.
module vpu_regfile #(
   parameter int W     = 64,
   parameter int NREG  = 8,
   parameter int NELEM = 64,
   parameter int NWP   = 3,
   parameter int NRP   = 5,
   localparam int RW   = $clog2(NREG),
   localparam int IW   = $clog2(NELEM),
   localparam int AW   = RW + IW
) (
   input  logic           clk,
   input  logic [NWP-1:0] we,
   input  logic [RW-1:0]  wreg  [NWP],
   input  logic [IW-1:0]  widx  [NWP],
   input  logic [W-1:0]   wdata [NWP],
   input  logic [RW-1:0]  rreg  [NRP],
   input  logic [IW-1:0]  ridx  [NRP],
   output logic [W-1:0]   rdata [NRP]
);
   logic [W-1:0] mem [NREG*NELEM];

   always_ff @(posedge clk) begin
      for (int k = 0; k < NWP; k++)
         if (we[k]) mem[{wreg[k], widx[k]}] <= wdata[k];
   end

   for (genvar p = 0; p < NRP; p++) begin : g_rd
      assign rdata[p] = mem[{rreg[p], ridx[p]}];
   end
endmodule

// File: rtl/vpu_scoreboard.sv
`timescale 1ns/1ps
// Per-element written flags: cleared for the active range of a new
// destination, set as each element is written back.
module vpu_scoreboard #(
   parameter int NREG  = 8,
   parameter int NELEM = 64,
   parameter int NW    = 2,
   localparam int RW   = $clog2(NREG),
   localparam int IW   = $clog2(NELEM),
   localparam int LW   = $clog2(NELEM + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_en,
   input  logic [RW-1:0]    clr_reg,
   input  logic [LW-1:0]    clr_len,
   input  logic [NW-1:0]    set_en,
   input  logic [RW-1:0]    set_reg [NW],
   input  logic [IW-1:0]    set_idx [NW],
   output logic [NELEM-1:0] flags   [NREG]
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < NREG; r++) flags[r] <= '1;
      end else begin
         for (int r = 0; r < NREG; r++)
            for (int e = 0; e < NELEM; e++)
               if (clr_en && clr_reg == RW'(r) && LW'(e) < clr_len)
                  flags[r][e] <= 1'b0;
         for (int k = 0; k < NW; k++)
            if (set_en[k]) flags[set_reg[k]][set_idx[k]] <= 1'b1;
      end
   end

   for (genvar k = 0; k < NW; k++) begin : g_chk
      // R7: a register being opened for writing is never written back that cycle
      p_no_setclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
         clr_en |-> !(set_en[k] && set_reg[k] == clr_reg));
   end
endmodule

// File: rtl/vpu_lane.sv
`timescale 1ns/1ps
// One execution lane: element sequencer plus its arithmetic pipeline.
module vpu_lane
   import vpu_chain_pkg::*;
#(
   parameter int W     = 64,
   parameter int NREG  = 8,
   parameter int NELEM = 64,
   parameter int DEPTH = 4,
   localparam int RW   = $clog2(NREG),
   localparam int IW   = $clog2(NELEM),
   localparam int LW   = $clog2(NELEM + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic [1:0]    in_op,
   input  logic [RW-1:0] in_vd,
   input  logic [RW-1:0] in_va,
   input  logic [RW-1:0] in_vb,
   input  logic [W-1:0]  in_s,
   input  logic [LW-1:0] in_len,
   output logic          active,
   output logic [RW-1:0] q_vd,
   output logic [RW-1:0] q_va,
   output logic [RW-1:0] q_vb,
   output logic [IW-1:0] rd_idx,
   input  logic          src_ok,
   input  logic [W-1:0]  rd_a,
   input  logic [W-1:0]  rd_b,
   output logic          wr_en,
   output logic [RW-1:0] wr_reg,
   output logic [IW-1:0] wr_idx,
   output logic [W-1:0]  wr_data,
   output logic          done
);
   logic [1:0]    op_q;
   logic [W-1:0]  s_q;
   logic [LW-1:0] len_q, idx_q;
   logic          issue, last;
   logic          f_vld;
   logic [W-1:0]  f_data;
   logic [IW-1:0] f_tag;

   assign issue  = active && (idx_q < len_q) && src_ok;
   assign rd_idx = idx_q[IW-1:0];

   vpu_fu #(.W(W), .DEPTH(DEPTH), .TW(IW)) u_fu (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (issue),
      .in_op   (op_q),
      .in_a    (rd_a),
      .in_b    (rd_b),
      .in_s    (s_q),
      .in_tag  (idx_q[IW-1:0]),
      .out_vld (f_vld),
      .out_data(f_data),
      .out_tag (f_tag)
   );

   assign last = f_vld && (LW'(f_tag) == len_q - LW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         done   <= 1'b0;
         idx_q  <= '0;
         len_q  <= '0;
         op_q   <= '0;
         q_vd   <= '0;
         q_va   <= '0;
         q_vb   <= '0;
         s_q    <= '0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            active <= 1'b1;
            op_q   <= in_op;
            q_vd   <= in_vd;
            q_va   <= in_va;
            q_vb   <= in_vb;
            s_q    <= in_s;
            len_q  <= in_len;
            idx_q  <= '0;
         end else if (active) begin
            if (issue) idx_q <= idx_q + LW'(1);
            if (last) begin
               active <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

   assign wr_en   = f_vld;
   assign wr_reg  = q_vd;
   assign wr_idx  = f_tag;
   assign wr_data = f_data;

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_accept_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (vop_e'(in_op) != VOP_RSV && in_len != '0
                  && in_len <= LW'(NELEM) && !active));
   p_wr_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (LW'(wr_idx) < len_q));
endmodule

// File: rtl/vpu_chain_unit.sv
`timescale 1ns/1ps
module vpu_chain_unit
   import vpu_chain_pkg::*;
#(
   parameter int W     = 64,
   parameter int NREG  = 8,
   parameter int NELEM = 64,
   parameter int DEPTH = 4,
   parameter int LANES = 2,
   localparam int RW   = $clog2(NREG),
   localparam int IW   = $clog2(NELEM),
   localparam int LW   = $clog2(NELEM + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       op,
   input  logic [RW-1:0]    vd,
   input  logic [RW-1:0]    va,
   input  logic [RW-1:0]    vb,
   input  logic [W-1:0]     scalar,
   input  logic [LW-1:0]    vlen,
   output logic             busy,
   output logic [LANES-1:0] done,
   input  logic             hw_en,
   input  logic [RW-1:0]    hw_reg,
   input  logic [IW-1:0]    hw_idx,
   input  logic [W-1:0]     hw_data,
   input  logic [RW-1:0]    hr_reg,
   input  logic [IW-1:0]    hr_idx,
   output logic [W-1:0]     hr_data
);
   localparam int NWP = LANES + 1;
   localparam int NRP = 2 * LANES + 1;
   localparam int LPW = (LANES > 1) ? $clog2(LANES) : 1;

   initial begin : g_param_chk
      assert (LANES >= 1) else $error("vpu_chain_unit: LANES must be positive");
      assert ((1 << RW) == NREG) else $error("vpu_chain_unit: NREG must be a power of two");
      assert ((1 << IW) == NELEM) else $error("vpu_chain_unit: NELEM must be a power of two");
   end

   logic [LANES-1:0] l_active, l_accept, l_src_ok, l_wr_en;
   logic [RW-1:0]    l_vd [LANES];
   logic [RW-1:0]    l_va [LANES];
   logic [RW-1:0]    l_vb [LANES];
   logic [IW-1:0]    l_idx [LANES];
   logic [RW-1:0]    l_wr_reg [LANES];
   logic [IW-1:0]    l_wr_idx [LANES];
   logic [W-1:0]     l_wr_data [LANES];

   logic [NWP-1:0]   rf_we;
   logic [RW-1:0]    rf_wreg [NWP];
   logic [IW-1:0]    rf_widx [NWP];
   logic [W-1:0]     rf_wdata [NWP];
   logic [RW-1:0]    rf_rreg [NRP];
   logic [IW-1:0]    rf_ridx [NRP];
   logic [W-1:0]     rf_rdata [NRP];
   logic [NELEM-1:0] flags [NREG];

   // issue decision
   logic           conflict, legal, found;
   logic [LPW-1:0] pick;

   always_comb begin
      conflict = 1'b0;
      for (int i = 0; i < LANES; i++)
         if (l_active[i] && (vd == l_vd[i] || vd == l_va[i] || vd == l_vb[i]))
            conflict = 1'b1;
   end

   always_comb begin
      pick  = '0;
      found = 1'b0;
      for (int i = 0; i < LANES; i++)
         if (!l_active[i] && !found) begin
            pick  = LPW'(i);
            found = 1'b1;
         end
   end

   assign legal = start && (vop_e'(op) != VOP_RSV) && (vlen != '0)
                  && (vlen <= LW'(NELEM)) && !conflict && found;
   assign busy  = &l_active;

   // host port is write port 0 / read port 0, so lanes take priority
   assign rf_we[0]    = hw_en;
   assign rf_wreg[0]  = hw_reg;
   assign rf_widx[0]  = hw_idx;
   assign rf_wdata[0] = hw_data;
   assign rf_rreg[0]  = hr_reg;
   assign rf_ridx[0]  = hr_idx;
   assign hr_data     = rf_rdata[0];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign l_accept[i] = legal && (pick == LPW'(i));
      assign l_src_ok[i] = (flags[l_va[i]][l_idx[i]] || l_va[i] == l_vd[i])
                        && (flags[l_vb[i]][l_idx[i]] || l_vb[i] == l_vd[i]);

      assign rf_we[i+1]      = l_wr_en[i];
      assign rf_wreg[i+1]    = l_wr_reg[i];
      assign rf_widx[i+1]    = l_wr_idx[i];
      assign rf_wdata[i+1]   = l_wr_data[i];
      assign rf_rreg[2*i+1]  = l_va[i];
      assign rf_ridx[2*i+1]  = l_idx[i];
      assign rf_rreg[2*i+2]  = l_vb[i];
      assign rf_ridx[2*i+2]  = l_idx[i];

      vpu_lane #(.W(W), .NREG(NREG), .NELEM(NELEM), .DEPTH(DEPTH)) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .accept (l_accept[i]),
         .in_op  (op),
         .in_vd  (vd),
         .in_va  (va),
         .in_vb  (vb),
         .in_s   (scalar),
         .in_len (vlen),
         .active (l_active[i]),
         .q_vd   (l_vd[i]),
         .q_va   (l_va[i]),
         .q_vb   (l_vb[i]),
         .rd_idx (l_idx[i]),
         .src_ok (l_src_ok[i]),
         .rd_a   (rf_rdata[2*i+1]),
         .rd_b   (rf_rdata[2*i+2]),
         .wr_en  (l_wr_en[i]),
         .wr_reg (l_wr_reg[i]),
         .wr_idx (l_wr_idx[i]),
         .wr_data(l_wr_data[i]),
         .done   (done[i])
      );

      for (genvar j = i + 1; j < LANES; j++) begin : g_pair
         p_wr_distinct_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (l_wr_en[i] && l_wr_en[j]) |-> (l_wr_reg[i] != l_wr_reg[j]));
      end
   end

   vpu_regfile #(.W(W), .NREG(NREG), .NELEM(NELEM), .NWP(NWP), .NRP(NRP)) u_rf (
      .clk  (clk),
      .we   (rf_we),
      .wreg (rf_wreg),
      .widx (rf_widx),
      .wdata(rf_wdata),
      .rreg (rf_rreg),
      .ridx (rf_ridx),
      .rdata(rf_rdata)
   );

   vpu_scoreboard #(.NREG(NREG), .NELEM(NELEM), .NW(LANES)) u_sb (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_en (|l_accept),
      .clr_reg(vd),
      .clr_len(vlen),
      .set_en (l_wr_en),
      .set_reg(l_wr_reg),
      .set_idx(l_wr_idx),
      .flags  (flags)
   );

   p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($countones(l_active) <= $past($countones(l_active))));
endmodule

// File: tb/vpu_chain_unit_test.sv
`timescale 1ns/1ps
module vpu_chain_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = '0;
   logic [2:0]  vd = '0, va = '0, vb = '0;
   logic [63:0] scalar = '0;
   logic [6:0]  vlen = '0;
   logic        busy;
   logic [1:0]  done;
   logic        hw_en = 1'b0;
   logic [2:0]  hw_reg = '0;
   logic [5:0]  hw_idx = '0;
   logic [63:0] hw_data = '0;
   logic [2:0]  hr_reg = '0;
   logic [5:0]  hr_idx = '0;
   logic [63:0] hr_data;

   int total = 0;
   int bad = 0;
   logic [63:0] mdl [8][64];

   always #2.5 clk = ~clk;

   vpu_chain_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vd(vd), .va(va), .vb(vb),
      .scalar(scalar), .vlen(vlen), .busy(busy), .done(done),
      .hw_en(hw_en), .hw_reg(hw_reg), .hw_idx(hw_idx), .hw_data(hw_data),
      .hr_reg(hr_reg), .hr_idx(hr_idx), .hr_data(hr_data)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input int r, input int e, output logic [63:0] v);
      hr_reg = 3'(r);
      hr_idx = 6'(e);
      #0.01;
      v = hr_data;
   endtask

   task automatic check_reg(input int r, input string rin, input string rout, input int n);
      logic [63:0] v;
      for (int e = 0; e < 64; e++) begin
         rd(r, e, v);
         chk(v == mdl[r][e], (e < n) ? rin : rout, v, mdl[r][e]);
      end
   endtask

   task automatic model(input int o, input int d, input int a, input int b, input logic [63:0] s, input int n);
      for (int e = 0; e < n; e++) begin
         logic [63:0] x, y;
         x = mdl[a][e];
         y = mdl[b][e];
         case (o)
            0: mdl[d][e] = x + y;
            1: mdl[d][e] = x * y;
            default: mdl[d][e] = x * s + y;
         endcase
      end
   endtask

   task automatic drive(input int o, input int d, input int a, input int b, input logic [63:0] s, input int n);
      start = 1'b1; op = 2'(o); vd = 3'(d); va = 3'(a); vb = 3'(b); scalar = s; vlen = 7'(n);
   endtask

   // runs one instruction on an idle unit, checks latency, pulse width and data
   task automatic run_op(input int o, input int d, input int a, input int b, input logic [63:0] s,
                         input int n, input string rdat);
      int cnt;
      @(negedge clk);
      drive(o, d, a, b, s, n);
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cnt = 0;
      for (int k = 0; k < 300; k++) begin
         @(posedge clk);
         cnt++;
         @(negedge clk);
         if (done[0]) break;
      end
      chk(cnt == n + 4, "R6 latency", 64'(cnt), 64'(n + 4));
      @(posedge clk);
      @(negedge clk);
      chk(done == 2'b00, "R6 pulse width", 64'(done), 64'd0);
      model(o, d, a, b, s, n);
      check_reg(d, rdat, "R5 tail unchanged", n);
   endtask

   task automatic try_refused(input int o, input int d, input int n, input string req);
      int seen = 0;
      @(negedge clk);
      drive(o, d, 0, 1, 64'd5, n);
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 80; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (done != 2'b00) seen++;
      end
      chk(seen == 0, req, 64'(seen), 64'd0);
      check_reg(d, req, req, 64);
   endtask

   task automatic t_reset;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(busy == 1'b0, "R1 busy in reset", 64'(busy), 64'd0);
      chk(done == 2'b00, "R1 done in reset", 64'(done), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && done == 2'b00, "R1 idle after reset", {62'd0, done}, 64'd0);
   endtask

   task automatic t_load;
      logic [63:0] v;
      for (int r = 0; r < 8; r++)
         for (int e = 0; e < 64; e++) begin
            if (r == 4) mdl[r][e] = ~64'(e);
            else if (r == 5) mdl[r][e] = 64'(e + 7);
            else mdl[r][e] = (64'h9E37_79B9_7F4A_7C15 * 64'(r * 64 + e + 1)) ^ (64'(r) << 56);
            @(negedge clk);
            hw_en = 1'b1; hw_reg = 3'(r); hw_idx = 6'(e); hw_data = mdl[r][e];
         end
      @(negedge clk);
      hw_en = 1'b0;
      rd(3, 63, v);
      chk(v == mdl[3][63], "R12 host readback", v, mdl[3][63]);
      rd(0, 0, v);
      chk(v == mdl[0][0], "R12 host readback", v, mdl[0][0]);
   endtask

   task automatic t_add;  run_op(0, 2, 0, 1, 64'd0, 64, "R2 add");             endtask
   task automatic t_wrap; run_op(0, 6, 4, 5, 64'd0, 64, "R2 add wraps");       endtask
   task automatic t_mul;  run_op(1, 3, 0, 1, 64'd0, 17, "R3 multiply");        endtask
   task automatic t_mac;  run_op(2, 7, 0, 2, 64'h0123_4567_89AB_CDEF, 1, "R4 multiply-add"); endtask
   task automatic t_inplace; run_op(0, 3, 3, 1, 64'd0, 64, "R10 in-place");    endtask

   task automatic t_chain;
      int cnt, cp, cc;
      cp = -1; cc = -1;
      @(negedge clk);
      drive(1, 6, 0, 1, 64'd0, 40);          // producer, lane 0
      @(posedge clk);
      @(negedge clk);
      drive(0, 7, 6, 2, 64'd0, 40);          // chained consumer, lane 1
      @(posedge clk);
      cnt = 1;
      @(negedge clk);
      chk(busy == 1'b1, "R8 busy with both lanes", 64'(busy), 64'd1);
      drive(0, 5, 0, 1, 64'd0, 64);          // must be dropped
      @(posedge clk);
      cnt = 2;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 300 && (cp < 0 || cc < 0); k++) begin
         @(posedge clk);
         cnt++;
         @(negedge clk);
         if (done[0]) cp = cnt;
         if (done[1]) cc = cnt;
      end
      chk(cp == 44, "R6 producer latency", 64'(cp), 64'd44);
      chk(cc - cp == 5, "R7 chained done spacing", 64'(cc - cp), 64'd5);
      model(1, 6, 0, 1, 64'd0, 40);
      model(0, 7, 6, 2, 64'd0, 40);
      check_reg(6, "R3 producer data", "R5 producer tail", 40);
      check_reg(7, "R7 chained data", "R5 consumer tail", 40);
      check_reg(5, "R8 dropped start", "R8 dropped start", 64);
   endtask

   task automatic t_refuse;
      int d0, d1;
      try_refused(3, 5, 64, "R9 reserved opcode");
      try_refused(0, 5, 0, "R9 zero length");
      try_refused(0, 5, 65, "R9 oversize length");
      d0 = 0; d1 = 0;
      @(negedge clk);
      drive(0, 5, 0, 1, 64'd0, 64);
      @(posedge clk);
      @(negedge clk);
      drive(1, 5, 4, 4, 64'd0, 64);          // same destination
      @(posedge clk);
      @(negedge clk);
      drive(1, 0, 4, 4, 64'd0, 64);          // overwrites a running source
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 100; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (done[0]) d0++;
         if (done[1]) d1++;
      end
      chk(d0 == 1, "R9 hazard producer done", 64'(d0), 64'd1);
      chk(d1 == 0, "R9 hazard starts refused", 64'(d1), 64'd0);
      model(0, 5, 0, 1, 64'd0, 64);
      check_reg(5, "R9 same destination refused", "R9 same destination refused", 64);
      check_reg(0, "R9 source overwrite refused", "R9 source overwrite refused", 64);
   endtask

   initial begin
      t_reset();
      t_load();
      t_add();
      t_wrap();
      t_mul();
      t_mac();
      t_inplace();
      t_chain();
      t_refuse();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule